// File: doc/BRIEF.md
# Masked Calendar Alarm Controller

This block watches a running calendar (second, minute, hour, date, month, day of week) and raises an alarm when the calendar equals a programmed alarm time. Each of the six alarm registers holds a 7-bit compare value and an enable bit. A field whose enable bit is clear is left out of the comparison, so one alarm setting can recur every minute, hour, day, month or year. The match is evaluated only in the cycle where the calendar's one-second strobe is high. As a result, a matching second produces exactly one alarm event.

A control register selects how an event is reported on the active-low interrupt pin. In latched mode the pin goes low and stays low until software clears the status flag. In pulsed mode every event drives the pin low for a fixed number of timebase cycles: 8192 cycles of a 32.768 kHz clock, which is 250 ms. A frequency-output enable bit in the same register shuts the alarm off completely while it is set. The clock of the block is the 32.768 kHz timebase.

Top module: `cal_alarm_ctrl`

## Requirements
- R1: After reset, `alarm_flag` is 0, `irq_n` is 1, every field enable is 0 and the control register is 0.
- R2: A write at address 0..5 (second, minute, hour, date, month, day of week) stores bit 7 as the field enable and bits 6:0 as the compare value. A match needs every enabled field to equal its calendar input, and fields that are not enabled are ignored.
- R3: With no field enabled, no alarm event ever occurs.
- R4: The match is evaluated only in a cycle with `sec_tick` high, and each such cycle gives at most one event.
- R5: With control bit 0 clear (latched mode), an event sets `alarm_flag` and drives `irq_n` low from the next cycle. `irq_n` stays low for as long as the flag is set.
- R6: `stat_clr` clears `alarm_flag` on the next edge. If an event occurs in the same cycle, the event wins and the flag stays 1.
- R7: With control bit 0 set (pulsed mode), an event sets `alarm_flag` and drives `irq_n` low for exactly PULSE_CYCLES cycles, starting the cycle after the event.
- R8: In pulsed mode every matching tick fires again. With only the second field enabled there is one event per 60 ticks. An event during a pulse restarts the full pulse length.
- R9: While control bit 1 (frequency output) is set, no event occurs, `irq_n` is held at 1 and any running pulse is abandoned. Clearing the bit does not bring back an abandoned pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | active-low synchronous reset |
| sec_tick | input | 1 | one-cycle strobe once per calendar second |
| cal_sec | input | 7 | current second |
| cal_min | input | 7 | current minute |
| cal_hour | input | 7 | current hour |
| cal_date | input | 7 | current date |
| cal_month | input | 7 | current month |
| cal_dow | input | 7 | current day of week |
| reg_wr_en | input | 1 | register write strobe |
| reg_wr_addr | input | 3 | 0..5 alarm fields, 6 control |
| reg_wr_data | input | 8 | write data |
| stat_clr | input | 1 | clear the alarm status flag |
| alarm_flag | output | 1 | alarm status bit |
| irq_n | output | 1 | active-low interrupt |

## Verification
The main sweep tries all 64 enable masks in latched mode. For each mask it uses a calendar that equals the alarm in every field, and six more calendars that each differ in exactly one field. This separates a disabled field that is correctly ignored from an enabled field that is wrongly ignored, and it also covers the empty mask. Pulsed-mode patterns measure the low time of `irq_n`, including a second event that arrives partway through a pulse. A two-minute run of ticks with only seconds enabled checks the recurring rate. Calendar matches without a tick, a clear that arrives together with an event, and frequency-output toggles made during a pulse test the ordering rules.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 7;
  localparam int REG_W      = FIELD_W + 1;
  localparam int ADDR_W     = 3;
  localparam int CTRL_ADDR  = NUM_FIELDS;

  typedef enum logic {MODE_LATCHED = 1'b0, MODE_PULSED = 1'b1} alarm_mode_e;

  typedef struct packed {
    logic        fout_en;
    alarm_mode_e mode;
  } alarm_ctrl_t;

  // A field passes when disabled, or when its value equals the calendar.
  function automatic logic field_pass(input logic [REG_W-1:0] areg,
                                      input logic [FIELD_W-1:0] now);
    return !areg[REG_W-1] || (areg[FIELD_W-1:0] == now);
  endfunction

  // Active-low interrupt level from control, flag and pulse state.
  function automatic logic irq_level_n(input alarm_ctrl_t ctrl,
                                       input logic flag,
                                       input logic pulse_on);
    if (ctrl.fout_en)                 return 1'b1;
    else if (ctrl.mode == MODE_PULSED) return !pulse_on;
    else                              return !flag;
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [REG_W-1:0]                  wr_data,
  output logic [NUM_FIELDS-1:0][REG_W-1:0]  alarm_regs,
  output alarm_ctrl_t                       ctrl
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        alarm_regs[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        alarm_regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.fout_en <= 1'b0;
      ctrl.mode    <= MODE_LATCHED;
    end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
      ctrl.fout_en <= wr_data[1];
      ctrl.mode    <= alarm_mode_e'(wr_data[0]);
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][REG_W-1:0]   alarm_regs,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal_now,
  input  logic                               sec_tick,
  input  logic                               fout_en,
  output logic                               any_field_en,
  output logic                               alarm_event
);
  logic [NUM_FIELDS-1:0] field_en;
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign field_en[i] = alarm_regs[i][REG_W-1];
    assign field_ok[i] = field_pass(alarm_regs[i], cal_now[i]);
  end

  assign any_field_en = |field_en;
  assign alarm_event  = sec_tick && any_field_en && (&field_ok) && !fout_en;
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 8192,
  parameter int unsigned CNT_W        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] cur,
                                                input logic ld,
                                                input logic ab);
    if (ab)            return '0;
    else if (ld)       return CNT_W'(PULSE_CYCLES);
    else if (cur != 0) return cur - 1'b1;
    else               return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(cnt, load, abort);
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cal_sec,
  input  logic [FIELD_W-1:0] cal_min,
  input  logic [FIELD_W-1:0] cal_hour,
  input  logic [FIELD_W-1:0] cal_date,
  input  logic [FIELD_W-1:0] cal_month,
  input  logic [FIELD_W-1:0] cal_dow,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [REG_W-1:0]   reg_wr_data,
  input  logic               stat_clr,
  output logic               alarm_flag,
  output logic               irq_n
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [NUM_FIELDS-1:0][REG_W-1:0]   alarm_regs;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal_now;
  alarm_ctrl_t                        ctrl;
  logic                               any_field_en;
  logic                               alarm_event;
  logic                               ctrl_pulse;
  logic                               ctrl_fout;
  logic                               pulse_load;
  logic                               pulse_abort;
  logic                               pulse_on;
  logic [CNT_W-1:0]                   pulse_cnt;

  assign cal_now = {cal_dow, cal_month, cal_date, cal_hour, cal_min, cal_sec};

  alarm_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .alarm_regs (alarm_regs),
    .ctrl       (ctrl)
  );

  assign ctrl_pulse = (ctrl.mode == MODE_PULSED);
  assign ctrl_fout  = ctrl.fout_en;

  alarm_match u_match (
    .alarm_regs   (alarm_regs),
    .cal_now      (cal_now),
    .sec_tick     (sec_tick),
    .fout_en      (ctrl_fout),
    .any_field_en (any_field_en),
    .alarm_event  (alarm_event)
  );

  assign pulse_load  = alarm_event && ctrl_pulse;
  assign pulse_abort = ctrl_fout || !ctrl_pulse;

  alarm_pulse_timer #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pulse_load),
    .abort  (pulse_abort),
    .cnt    (pulse_cnt),
    .active (pulse_on)
  );

  // Status flag: an event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)           alarm_flag <= 1'b0;
    else if (alarm_event) alarm_flag <= 1'b1;
    else if (stat_clr)    alarm_flag <= 1'b0;
  end

  assign irq_n = irq_level_n(ctrl, alarm_flag, pulse_on);
endmodule

// File: rtl/cal_alarm_ctrl_chk.sv
module cal_alarm_ctrl_chk #(
  parameter int unsigned PULSE_CYCLES = 8192,
  parameter int unsigned CNT_W        = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             stat_clr,
  input logic             alarm_event,
  input logic             alarm_flag,
  input logic             irq_n,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             any_field_en,
  input logic             ctrl_pulse,
  input logic             ctrl_fout
);
  assert_empty_mask_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_field_en |=> !$rose(alarm_flag));

  assert_tick_gates_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(alarm_flag));

  assert_latched_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_pulse && !ctrl_fout && alarm_flag) |-> !irq_n);

  assert_event_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_event |=> alarm_flag);

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !stat_clr) |=> alarm_flag);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !alarm_event) |=> !alarm_flag);

  assert_pulse_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_event && ctrl_pulse) |=> (pulse_cnt == CNT_W'(PULSE_CYCLES)));

  assert_pulse_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_pulse && !ctrl_fout && pulse_cnt != '0 && !alarm_event)
      |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

  assert_fout_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_fout |=> (pulse_cnt == '0 && !$rose(alarm_flag)));
endmodule

bind cal_alarm_ctrl cal_alarm_ctrl_chk #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .CNT_W        (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick     (sec_tick),
  .stat_clr     (stat_clr),
  .alarm_event  (alarm_event),
  .alarm_flag   (alarm_flag),
  .irq_n        (irq_n),
  .pulse_cnt    (pulse_cnt),
  .any_field_en (any_field_en),
  .ctrl_pulse   (ctrl_pulse),
  .ctrl_fout    (ctrl_fout)
);

// File: tb/cal_alarm_ctrl_tb_top.sv
module cal_alarm_ctrl_tb_top;
  localparam int PULSE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [6:0] cal [6];
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic       stat_clr = 1'b0;
  logic       alarm_flag;
  logic       irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  cal_alarm_ctrl #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .cal_sec     (cal[0]),
    .cal_min     (cal[1]),
    .cal_hour    (cal[2]),
    .cal_date    (cal[3]),
    .cal_month   (cal[4]),
    .cal_dow     (cal[5]),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .stat_clr    (stat_clr),
    .alarm_flag  (alarm_flag),
    .irq_n       (irq_n)
  );

  function automatic logic [6:0] base_val(input int f);
    case (f)
      0: return 7'd17;  1: return 7'd42;  2: return 7'd9;
      3: return 7'd23;  4: return 7'd11;  default: return 7'd4;
    endcase
  endfunction

  // Expected hit: some field enabled and no enabled field differs.
  function automatic bit exp_hit(input int mask, input int diff);
    return (mask != 0) && ((mask & diff) == 0);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic set_base(input int diff);
    for (int f = 0; f < 6; f++) cal[f] = base_val(f) + 7'(diff >> f & 1);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!irq_n && n < 10 * PULSE) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    int hits;
    set_base(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "flag after reset", alarm_flag, 0);
    check("R1", "irq_n after reset", irq_n, 1);
    tick();
    check("R1", "no alarm with reset enables", alarm_flag, 0);

    // R2/R3 sweep: all masks, latched mode (control = 0).
    for (int mask = 0; mask < 64; mask++) begin
      for (int f = 0; f < 6; f++) wr(3'(f), {mask[f], base_val(f)});
      for (int d = 0; d <= 6; d++) begin
        int diff;
        diff = (d == 6) ? 0 : (1 << d);
        set_base(diff);
        tick();
        check(mask == 0 ? "R3" : "R2", "sweep flag", alarm_flag, exp_hit(mask, diff));
        check("R5", "sweep irq_n", irq_n, !exp_hit(mask, diff));
        clr();
      end
    end

    // R4: matching calendar without tick.
    set_base(0);
    repeat (10) @(negedge clk);
    check("R4", "no event without tick", alarm_flag, 0);

    // R5: latched hold until clear.
    tick();
    repeat (30) @(negedge clk);
    check("R5", "irq_n held low", irq_n, 0);
    check("R5", "flag held", alarm_flag, 1);
    clr();
    check("R6", "clear drops flag", alarm_flag, 0);
    check("R5", "irq_n released", irq_n, 1);

    // R6: clear together with event.
    @(negedge clk); sec_tick = 1'b1; stat_clr = 1'b1;
    @(negedge clk); sec_tick = 1'b0; stat_clr = 1'b0;
    check("R6", "event beats clear", alarm_flag, 1);
    clr();

    // R7: pulsed mode length.
    wr(3'd6, 8'h01);
    tick();
    check("R7", "pulsed flag", alarm_flag, 1);
    count_low(n);
    check("R7", "pulse length", n, PULSE);
    check("R7", "flag after pulse", alarm_flag, 1);
    clr();

    // R8: retrigger restarts full length.
    tick();
    repeat (5) @(negedge clk);
    check("R8", "still low mid pulse", irq_n, 0);
    tick();
    count_low(n);
    check("R8", "retrigger length", n, PULSE);
    clr();

    // R8: seconds-only alarm at 30 over 120 ticks.
    wr(3'd0, {1'b1, 7'd30});
    for (int f = 1; f < 6; f++) wr(3'(f), 8'h00);
    hits = 0;
    for (int s = 0; s < 120; s++) begin
      cal[0] = 7'(s % 60);
      tick();
      if (alarm_flag) begin hits++; clr(); end
    end
    check("R8", "events in two minutes", hits, 2);
    repeat (2 * PULSE) @(negedge clk);

    // R9: frequency output blocks alarm.
    cal[0] = 7'd30;
    wr(3'd6, 8'h03);
    tick();
    check("R9", "no flag with fout", alarm_flag, 0);
    check("R9", "irq_n high with fout", irq_n, 1);
    wr(3'd6, 8'h01);
    tick();
    check("R9", "pulse starts", irq_n, 0);
    wr(3'd6, 8'h03);
    check("R9", "fout aborts pulse", irq_n, 1);
    wr(3'd6, 8'h01);
    check("R9", "aborted pulse stays gone", irq_n, 1);
    wr(3'd6, 8'h02);
    check("R9", "latched flag masked by fout", irq_n, 1);
    wr(3'd6, 8'h00);
    check("R5", "latched flag shows after fout off", irq_n, 0);
    clr();
    check("R6", "final clear", alarm_flag, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule